// File: doc/BRIEF.md
# Dual-Rail Four-Phase Shift Pipeline

This block is a cycle-level behavioural model of a pipelined shift register built from two-level adiabatic buffer stages. A datum travels as a short dual-rail pulse: one rail high means a value, both rails low means no datum, and both rails high is illegal. A rotating four-phase timing scheme clocks the stages. Stage k answers to phase k mod 4. A stage takes its input when its phase rises and goes back to neutral when that phase falls. As a result, each pulse moves forward exactly one stage per tick.

The `tick` input advances the phase sequence. On each tick exactly one phase rises and the phase before it falls. Between any two stages, and in front of the first one, a link can swap the two rails. A swap inverts the datum at no logic cost. A parameter mask picks which links swap. A sticky error flag records any input that breaks the pulse protocol.

Top module: `adp_shift_pipe`

## Requirements
- R1: After reset, `dout` is neutral (2'b00), `phase_hi` is 4'b0000 and `err` is low.
- R2: Rail encoding on `din` and `dout`: bit 0 is the zero rail and bit 1 is the one rail. Value 0 is 2'b01, value 1 is 2'b10, 2'b00 is neutral and 2'b11 is illegal. `dout` never shows 2'b11.
- R3: Ticks are numbered from 0 after reset, and the phase index of a tick is its number mod 4. A legal pulse on `din` during tick j, where j mod 4 is 0, is captured. It is shown on `dout` in the interval right after tick j+DEPTH-1 and is neutral again after tick j+DEPTH. With no pulse due, `dout` is neutral.
- R4: A pulse leaves inverted exactly when an odd number of bits in INV_MASK[DEPTH-1:0] are set. Bit k swaps the rails at the input of stage k.
- R5: Pulses entered every four ticks all leave in order, each with its own value and with no interference.
- R6: While `tick` is low, `dout` and `phase_hi` hold their values.
- R7: After tick j, `phase_hi` is one-hot with bit (j mod 4) set.
- R8: A valid pulse on `din` during a tick whose phase index is not 0 is not captured. It sets `err` in the following cycle.
- R9: 2'b11 on `din` during a tick sets `err` in the following cycle, and nothing leaves the pipeline for it.
- R10: `err` stays high until reset, and legal pulses still flow while it is set.
- R11: A valid `din` while `tick` is low is neither captured nor flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advances the four-phase sequence by one tick |
| din | input | 2 | Dual-rail input pulse {one rail, zero rail} |
| dout | output | 2 | Dual-rail output of the last stage |
| phase_hi | output | 4 | One-hot view of the phase that rose on the last tick |
| err | output | 1 | Sticky protocol-error flag |

## Verification
A pulse captured on tick j is due on `dout` only in the interval after tick j+DEPTH-1. The bench numbers every tick it issues and books the expected rail code for that tick number when the pulse enters. After each clock edge it compares `dout` and `phase_hi` with the booked values, so any early, late, doubled or lost pulse is seen on the exact cycle where it goes wrong. Error effects are due one cycle after the offending tick and are sampled there. Stalls are checked by confirming that no booking comes due while `tick` stays low.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int NPHASE = 4;
  localparam int PH_W   = $clog2(NPHASE);

  typedef logic [1:0] rail_t;

  localparam rail_t RAIL_NEUTRAL = 2'b00;
  localparam rail_t RAIL_ZERO    = 2'b01;
  localparam rail_t RAIL_ONE     = 2'b10;
  localparam rail_t RAIL_BAD     = 2'b11;

  function automatic rail_t rail_swap(input rail_t r);
    return {r[0], r[1]};
  endfunction

  function automatic logic rail_valid(input rail_t r);
    return (r == RAIL_ZERO) || (r == RAIL_ONE);
  endfunction
endpackage

// File: rtl/adp_phase_gen.sv
module adp_phase_gen
  import adp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [PH_W-1:0] idx,
  output logic [NPHASE-1:0] hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      hi  <= '0;
    end else if (tick) begin
      hi  <= NPHASE'(1) << idx;
      idx <= idx + PH_W'(1);
    end
  end
endmodule

// File: rtl/adp_stage.sv
module adp_stage
  import adp_pkg::*;
#(
  parameter logic [PH_W-1:0] PHASE = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [PH_W-1:0] idx,
  input  rail_t           d,
  output rail_t           q
);
  localparam logic [PH_W-1:0] FALL_PH = PHASE + PH_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RAIL_NEUTRAL;
    end else if (tick) begin
      if (idx == PHASE) begin
        q <= rail_valid(d) ? d : RAIL_NEUTRAL;
      end else if (idx == FALL_PH) begin
        q <= RAIL_NEUTRAL;
      end
    end
  end
endmodule

// File: rtl/adp_err_mon.sv
module adp_err_mon
  import adp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [PH_W-1:0] idx,
  input  rail_t           din,
  output logic            err
);
  logic bad_code;
  logic off_phase;

  always_comb begin
    bad_code  = (din == RAIL_BAD);
    off_phase = (din != RAIL_NEUTRAL) && (idx != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else if (tick && (bad_code || off_phase)) begin
      err <= 1'b1;
    end
  end
endmodule

// File: rtl/adp_shift_pipe.sv
module adp_shift_pipe
  import adp_pkg::*;
#(
  parameter int          DEPTH    = 8,
  parameter logic [15:0] INV_MASK = 16'h0025
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] din,
  output logic [1:0] dout,
  output logic [3:0] phase_hi,
  output logic       err
);
  logic [PH_W-1:0] idx;
  rail_t           link [DEPTH];
  rail_t           stq  [DEPTH];

  adp_phase_gen u_phase (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .idx (idx),
    .hi  (phase_hi)
  );

  adp_err_mon u_err (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .idx (idx),
    .din (din),
    .err (err)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    localparam logic [PH_W-1:0] PH = PH_W'(k % NPHASE);
    rail_t src;

    if (k == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = stq[k-1];
    end

    if (INV_MASK[k]) begin : g_swap
      assign link[k] = rail_swap(src);
    end else begin : g_pass
      assign link[k] = src;
    end

    adp_stage #(.PHASE(PH)) u_stage (
      .clk (clk),
      .rst (rst),
      .tick(tick),
      .idx (idx),
      .d   (link[k]),
      .q   (stq[k])
    );
  end

  assign dout = stq[DEPTH-1];
endmodule

// File: rtl/adp_shift_pipe_chk.sv
module adp_shift_pipe_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [1:0] din,
  input logic [1:0] dout,
  input logic [3:0] phase_hi,
  input logic       err
);
  p_dout_legal_r2: assert property (@(posedge clk) disable iff (rst)
    dout != 2'b11);

  p_pulse_short_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && dout != 2'b00) |=> (dout == 2'b00));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(dout) && $stable(phase_hi)));

  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase_hi));

  p_rotate_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && phase_hi != 4'b0000) |=> (phase_hi == {$past(phase_hi[2:0]), $past(phase_hi[3])}));

  p_bad_code_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && din == 2'b11) |=> err);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind adp_shift_pipe adp_shift_pipe_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .din     (din),
  .dout    (dout),
  .phase_hi(phase_hi),
  .err     (err)
);

// File: tb/adp_shift_pipe_tb.sv
module adp_shift_pipe_tb_top;
  localparam int          N    = 8;
  localparam logic [15:0] MASK = 16'h0025;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] din = 2'b00;
  logic [1:0] dout;
  logic [3:0] phase_hi;
  logic       err;

  int   checks = 0;
  int   fails  = 0;
  int   tk     = 0;
  bit   done   = 0;
  logic [1:0] sched [256];
  logic [1:0] exp_dout = 2'b00;
  logic [3:0] exp_ph   = 4'b0000;

  always #4 clk = ~clk;

  adp_shift_pipe #(.DEPTH(N), .INV_MASK(MASK)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .din(din),
    .dout(dout), .phase_hi(phase_hi), .err(err)
  );

  function automatic logic inv_par();
    logic p = 1'b0;
    for (int i = 0; i < N; i++) p ^= MASK[i];
    return p;
  endfunction

  function automatic logic [1:0] enc(input logic v);
    return v ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (tick %0d)", req, act, exp, tk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0; din = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tk = 0;
    for (int i = 0; i < 256; i++) sched[i] = 2'b00;
    exp_dout = 2'b00;
    exp_ph   = 4'b0000;
  endtask

  // one cycle: drive, book expectation per R3/R4, sample at negedge
  task automatic step(input logic [1:0] d, input logic t);
    if (t && (tk % 4 == 0) && (d == 2'b01 || d == 2'b10))
      sched[(tk + N - 1) % 256] = enc(d[1] ^ inv_par());
    din = d; tick = t;
    @(posedge clk);
    @(negedge clk);
    if (t) begin
      exp_dout = sched[tk % 256];
      sched[tk % 256] = 2'b00;
      exp_ph = 4'b0001 << (tk % 4);
      tk++;
    end
  endtask

  task automatic step_chk(input logic [1:0] d, input logic t, input string req);
    step(d, t);
    chk({req, " dout"}, {2'b00, dout}, {2'b00, exp_dout});
    chk("R7 phase_hi", phase_hi, exp_ph);
  endtask

  task automatic align(input int ph, input string req);
    while (tk % 4 != ph) step_chk(2'b00, 1'b1, req);
  endtask

  task automatic t_reset();
    chk("R1 dout", {2'b00, dout}, 4'h0);
    chk("R1 phase_hi", phase_hi, 4'h0);
    chk("R1 err", {3'b000, err}, 4'h0);
  endtask

  task automatic t_single();
    align(0, "R3");
    step_chk(2'b10, 1'b1, "R4 one");
    for (int i = 0; i < N + 2; i++) step_chk(2'b00, 1'b1, "R3");
    align(0, "R3");
    step_chk(2'b01, 1'b1, "R2 zero");
    for (int i = 0; i < N + 2; i++) step_chk(2'b00, 1'b1, "R4");
    chk("R2 err", {3'b000, err}, 4'h0);
  endtask

  task automatic t_stream();
    logic [5:0] pat = 6'b011001;
    align(0, "R5");
    for (int p = 0; p < 6; p++) begin
      step_chk(enc(pat[p]), 1'b1, "R5");
      for (int i = 0; i < 3; i++) step_chk(2'b00, 1'b1, "R5");
    end
    for (int i = 0; i < N + 2; i++) step_chk(2'b00, 1'b1, "R5");
  endtask

  task automatic t_stall();
    align(0, "R6");
    step_chk(2'b10, 1'b1, "R6");
    step_chk(2'b00, 1'b1, "R6");
    for (int i = 0; i < 3; i++) step_chk(2'b01, 1'b0, "R11");
    chk("R11 err", {3'b000, err}, 4'h0);
    for (int i = 0; i < N + 2; i++) step_chk(2'b00, 1'b1, "R6");
  endtask

  task automatic t_offphase();
    align(1, "R8");
    step_chk(2'b10, 1'b1, "R8");
    chk("R8 err", {3'b000, err}, 4'h1);
    for (int i = 0; i < N + 2; i++) step_chk(2'b00, 1'b1, "R8");
    chk("R10 err held", {3'b000, err}, 4'h1);
    do_reset();
    chk("R10 err cleared", {3'b000, err}, 4'h0);
  endtask

  task automatic t_badcode();
    align(0, "R9");
    step_chk(2'b11, 1'b1, "R9");
    chk("R9 err", {3'b000, err}, 4'h1);
    for (int i = 0; i < N + 2; i++) step_chk(2'b00, 1'b1, "R9");
    align(0, "R10");
    step_chk(2'b01, 1'b1, "R10");
    for (int i = 0; i < N + 2; i++) step_chk(2'b00, 1'b1, "R10");
    chk("R10 err", {3'b000, err}, 4'h1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_single();
    t_stream();
    t_stall();
    t_offphase();
    t_badcode();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule